// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block shares one bus among a set of masters, each with its own request line and grant line. Every master belongs either to a high-priority group or to a low-priority group. A requesting high-group master always wins over any requesting low-group master. Inside each group, grants rotate round-robin, and each group has its own rotation pointer. A latency count limits how long an owner may keep the bus once another master is competing for it. When no eligible master is requesting, the grant stays parked on the last owner.

A small register port sets the group of each master, sets a per-master disable bit, and holds the latency count. It also holds a multi-transaction timer value. That value is only stored and read back; it resets to zero, which means disabled. A register-file reset returns all registers to their defaults. A separate bus reset clears only the arbitration state (grant, state, pointers and counter) and keeps the programmed registers.

The controller is a three-state machine. ST_IDLE means no grant is asserted. ST_GRANT means an owner holds the bus. ST_PARK means the grant is kept on an owner that has stopped requesting. The transitions are as follows:
- issue: any of ST_IDLE, ST_GRANT or ST_PARK goes to ST_GRANT when a new winner is granted.
- park: ST_GRANT goes to ST_PARK when nothing eligible is requesting.
- retire: ST_GRANT or ST_PARK goes to ST_IDLE when the owner has become disabled and nothing eligible is requesting.
- hold: any state stays where it is otherwise.

Top module: `arb_two_level`

## Requirements
- R1: After the register reset, the registers read as follows. Address 0 (group map, bit i = 1 puts master i in the high group) reads 0x1. Address 1 (disable mask, bit i = 1 disables master i) reads 0. Address 2 (latency count) reads 0xFFF. Address 3 (multi-transaction timer) reads 0. No grant is asserted.
- R2: When a new grant is issued and any eligible high-group master is a candidate, the winner is a high-group master.
- R3: Within a group, the winner is the first candidate found searching upward (with wrap) from that group's pointer. After a grant, the pointer moves to the master just after the winner.
- R4: After either reset, both group pointers point at master 0.
- R5: A bus reset clears the grant, the state and the pointers. The group map, disable mask and latency registers keep their programmed values.
- R6: A granted owner that keeps requesting loads the latency count L at its grant. On each later edge that sees a competing eligible request, the owner keeps the bus while the count is nonzero and the count decreases by one. At the (L+1)th such edge, the grant moves to another master. Edges without a competing request leave the count unchanged.
- R7: A disabled master is never granted. If the owner is disabled and no eligible request exists, the grant is removed.
- R8: With no eligible request, the grant stays on the last owner (parking).
- R9: At most one grant is asserted at a time. A grant changes only on a clock edge, one cycle after the requests that cause it.
- R10: Register writes take effect at the clock edge. Every register, including the multi-transaction timer, reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register-file and arbiter reset |
| bus_rst_n | input | 1 | Asynchronous active-low bus reset, arbiter state only |
| req | input | NUM_MASTERS | Request line per master |
| gnt | output | NUM_MASTERS | One-hot grant per master |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 group map, 1 disable, 2 latency, 3 multi-transaction timer) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |

## Verification
The arbiter is driven with several request patterns. Three low-group masters competing shows rotation and the latency hand-over. A single high master against a low master shows that priority holds while the low master waits. With two masters in each group and everyone requesting, low-group starvation and the high-group wrap become visible. A lone owner later joined by a competitor shows that the count is frozen while the owner is uncontended. Requests that include only disabled masters separate masking from parking. A request pattern issued right after a bus reset tells a restarted pointer from a stale one.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_PARK  = 2'd2
    } arb_state_e;

    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] RA_GROUP = 2'd0;
    localparam logic [REG_ADDR_W-1:0] RA_DIS   = 2'd1;
    localparam logic [REG_ADDR_W-1:0] RA_LAT   = 2'd2;
    localparam logic [REG_ADDR_W-1:0] RA_MTT   = 2'd3;

endpackage

// File: rtl/arb_regs.sv
module arb_regs
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int LAT_W       = 12,
    parameter int MTT_W       = 8,
    parameter int DATA_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic [NUM_MASTERS-1:0] grp_hi,
    output logic [NUM_MASTERS-1:0] dis,
    output logic [LAT_W-1:0]      lat
);

    localparam logic [NUM_MASTERS-1:0] GROUP_RST = {{(NUM_MASTERS-1){1'b0}}, 1'b1};

    logic [MTT_W-1:0] mtt_q;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_hi <= GROUP_RST;
            dis    <= '0;
            lat    <= '1;
            mtt_q  <= '0;
        end else if (we) begin
            unique case (addr)
                RA_GROUP: grp_hi <= wdata[NUM_MASTERS-1:0];
                RA_DIS:   dis    <= wdata[NUM_MASTERS-1:0];
                RA_LAT:   lat    <= wdata[LAT_W-1:0];
                RA_MTT:   mtt_q  <= wdata[MTT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_GROUP: rdata[NUM_MASTERS-1:0] = grp_hi;
            RA_DIS:   rdata[NUM_MASTERS-1:0] = dis;
            RA_LAT:   rdata[LAT_W-1:0]       = lat;
            RA_MTT:   rdata[MTT_W-1:0]       = mtt_q;
            default:  rdata = '0;
        endcase
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_LAT) |=> (lat == $past(wdata[LAT_W-1:0]))); // R10

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] ptr,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        int             pos;
        logic [IDX_W-1:0] p;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            pos = int'(ptr) + k;
            if (pos >= N) pos = pos - N;
            p = pos[IDX_W-1:0];
            if (!found && req[p]) begin
                found = 1'b1;
                idx   = p;
            end
        end
    end

    AST_PICK_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> req[idx]); // R3

    AST_PICK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> found); // R3

endmodule

// File: rtl/arb_lat_timer.sv
module arb_lat_timer #(
    parameter int LAT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [LAT_W-1:0] lat,
    output logic             cnt_zero
);

    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= lat;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_zero = (cnt_q == '0);

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(lat))); // R6

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/arb_two_level.sv
module arb_two_level
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int LAT_W       = 12,
    parameter int MTT_W       = 8,
    parameter int DATA_W      = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    output logic [NUM_MASTERS-1:0] gnt,
    input  logic                   reg_we,
    input  logic [REG_ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata
);

    localparam int N     = NUM_MASTERS;
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int NGRP  = 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);
    localparam logic [N-1:0]     ONE_HOT0 = {{(N-1){1'b0}}, 1'b1};

    logic             arb_rst_n;
    logic [N-1:0]     grp_hi;
    logic [N-1:0]     dis;
    logic [LAT_W-1:0] lat;

    arb_state_e       state_q, state_d;
    logic [N-1:0]     gnt_q, gnt_d;
    logic [IDX_W-1:0] ptr_q [NGRP];

    logic [N-1:0]     elig, others, cand;
    logic             owner_act, owner_dis;
    logic [N-1:0]     grp_req   [NGRP];
    logic             grp_found [NGRP];
    logic [IDX_W-1:0] grp_idx   [NGRP];
    logic             win_any, win_hi;
    logic [IDX_W-1:0] win_idx, ptr_nx;
    logic [N-1:0]     win_oh;
    logic             issue, cnt_dec, cnt_zero;

    assign arb_rst_n = rst_n & bus_rst_n;

    arb_regs #(
        .NUM_MASTERS(N), .LAT_W(LAT_W), .MTT_W(MTT_W), .DATA_W(DATA_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .grp_hi(grp_hi), .dis(dis), .lat(lat)
    );

    assign elig      = req & ~dis;
    assign others    = elig & ~gnt_q;
    assign owner_act = |(elig & gnt_q);
    assign owner_dis = |(gnt_q & dis);

    // Candidate set: an active owner competes only against the others.
    always_comb begin
        unique case (state_q)
            ST_GRANT: cand = others;
            default:  cand = elig;
        endcase
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_req[g] = cand & ((g == 1) ? grp_hi : ~grp_hi);
        arb_rr_pick #(.N(N), .IDX_W(IDX_W)) i_pick (
            .clk(clk), .rst_n(arb_rst_n),
            .req(grp_req[g]), .ptr(ptr_q[g]),
            .found(grp_found[g]), .idx(grp_idx[g])
        );
    end

    assign win_hi  = grp_found[1];
    assign win_any = grp_found[0] | grp_found[1];
    assign win_idx = win_hi ? grp_idx[1] : grp_idx[0];
    assign win_oh  = win_any ? (ONE_HOT0 << win_idx) : '0;
    assign ptr_nx  = (win_idx == LAST_IDX) ? '0 : win_idx + 1'b1;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        gnt_d   = gnt_q;
        issue   = 1'b0;
        cnt_dec = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (win_any) issue = 1'b1;
            end
            ST_GRANT: begin
                if (owner_act) begin
                    if (others != '0) begin
                        if (cnt_zero) issue = 1'b1;
                        else          cnt_dec = 1'b1;
                    end
                end else if (others != '0) begin
                    issue = 1'b1;
                end else if (owner_dis) begin
                    state_d = ST_IDLE;
                    gnt_d   = '0;
                end else begin
                    state_d = ST_PARK;
                end
            end
            ST_PARK: begin
                if (win_any) begin
                    issue = 1'b1;
                end else if (owner_dis) begin
                    state_d = ST_IDLE;
                    gnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                gnt_d   = '0;
            end
        endcase
        if (issue) begin
            state_d = ST_GRANT;
            gnt_d   = win_oh;
        end
    end

    // State register
    always_ff @(posedge clk or negedge arb_rst_n) begin
        if (!arb_rst_n) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    // Outputs and rotation pointers
    always_ff @(posedge clk or negedge arb_rst_n) begin
        if (!arb_rst_n) begin
            gnt_q <= '0;
            for (int g = 0; g < NGRP; g++) ptr_q[g] <= '0;
        end else begin
            gnt_q <= gnt_d;
            if (issue) ptr_q[win_hi] <= ptr_nx;
        end
    end

    assign gnt = gnt_q;

    arb_lat_timer #(.LAT_W(LAT_W)) i_timer (
        .clk(clk), .rst_n(arb_rst_n), .load(issue), .dec(cnt_dec),
        .lat(lat), .cnt_zero(cnt_zero)
    );

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!arb_rst_n)
        $onehot0(gnt_q)); // R9

    AST_HIGH_WINS: assert property (@(posedge clk) disable iff (!arb_rst_n)
        (issue && (cand & grp_hi) != '0) |-> ((win_oh & grp_hi) != '0)); // R2

    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!arb_rst_n)
        (state_q == ST_GRANT && owner_act && !cnt_zero) |=> $stable(gnt_q)); // R6

    AST_PARK_KEEP: assert property (@(posedge clk) disable iff (!arb_rst_n)
        (state_q == ST_PARK && elig == '0 && !owner_dis) |=> $stable(gnt_q)); // R8

    AST_NO_DISABLED_WIN: assert property (@(posedge clk) disable iff (!arb_rst_n)
        (gnt_q != $past(gnt_q) && gnt_q != '0) |-> ((gnt_q & $past(req & ~dis)) != '0)); // R7

endmodule

// File: tb/test_arb_two_level.sv
module test_arb_two_level;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  gnt;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;

    int checks = 0;
    int fails  = 0;

    logic [N-1:0] exp_q [$];
    string        tag_q [$];

    arb_two_level #(.NUM_MASTERS(N)) i_arb_two_level (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .req(req), .gnt(gnt),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare the grant after each edge with the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                logic [N-1:0] e;
                string        t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (gnt !== e) begin
                    fails++;
                    $display("FAIL %s: gnt actual %b expected %b", t, gnt, e);
                end
            end
        end
    end

    // Driver: apply requests, push the grant expected after the next edge
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] e, input string t);
        @(negedge clk);
        req = r;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        req       = '0;
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s: rdata[%0d] actual %h expected %h", t, a, reg_rdata, e);
        end
    endtask

    task automatic chk_gnt(input logic [N-1:0] e, input string t);
        #1;
        checks++;
        if (gnt !== e) begin
            fails++;
            $display("FAIL %s: gnt actual %b expected %b", t, gnt, e);
        end
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
        req = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_rst_n = 1'b1;

        // R1 reset defaults
        chk_gnt(4'b0000, "R1 no grant after reset");
        rd(2'd0, 32'h1,   "R1 group map default");
        rd(2'd1, 32'h0,   "R1 disable default");
        rd(2'd2, 32'hFFF, "R1 latency default");
        rd(2'd3, 32'h0,   "R1 timer default");

        wr(2'd2, 32'd1);
        rd(2'd2, 32'd1, "R10 latency write");

        // Low group rotation, latency 1
        step(4'b1110, 4'b0010, "R4 rotation starts at lowest");
        step(4'b1110, 4'b0010, "R6 held while count nonzero");
        step(4'b1110, 4'b0100, "R3 R6 hand-over to next");
        step(4'b1010, 4'b1000, "R3 owner drops, next in rotation");
        step(4'b0010, 4'b0010, "R3 wrap to master 1");
        step(4'b0000, 4'b0010, "R8 parked");
        step(4'b0000, 4'b0010, "R8 still parked");

        // High master 0 versus low master 1
        step(4'b0011, 4'b0001, "R2 high wins");
        step(4'b0011, 4'b0001, "R6 high holds");
        step(4'b0011, 4'b0010, "R6 expiry gives low a turn");
        step(4'b0011, 4'b0010, "R6 low holds");
        step(4'b0011, 4'b0001, "R2 back to high");
        step(4'b0000, 4'b0001, "R8 parked on high");

        // Masters 1 and 3 high
        wr(2'd0, 32'hA);
        step(4'b1111, 4'b0010, "R2 R3 high group pick");
        step(4'b1111, 4'b0010, "R6 hold");
        step(4'b1111, 4'b1000, "R2 R3 next high");
        step(4'b1111, 4'b1000, "R6 hold");
        step(4'b1111, 4'b0010, "R3 high wrap, low starved");
        step(4'b0101, 4'b0100, "R3 low pointer kept");
        step(4'b0000, 4'b0100, "R8 parked");

        // Disable master 2
        wr(2'd1, 32'h4);
        step(4'b0000, 4'b0000, "R7 disabled owner loses grant");
        step(4'b0100, 4'b0000, "R7 disabled request ignored");
        step(4'b0101, 4'b0001, "R7 enabled master granted");
        step(4'b0000, 4'b0001, "R8 parked");
        drain();

        wr(2'd3, 32'h5A);
        rd(2'd3, 32'h5A, "R10 timer readback");

        // Bus reset keeps programmed registers
        @(negedge clk);
        bus_rst_n = 1'b0;
        chk_gnt(4'b0000, "R5 bus reset clears grant");
        @(negedge clk);
        bus_rst_n = 1'b1;
        rd(2'd0, 32'hA, "R5 group map kept");
        rd(2'd1, 32'h4, "R5 disable kept");
        rd(2'd2, 32'h1, "R5 latency kept");
        step(4'b1010, 4'b0010, "R4 R5 pointer restarted");
        step(4'b0000, 4'b0010, "R8 parked");

        // Count frozen while uncontended, latency 3
        wr(2'd2, 32'd3);
        step(4'b1010, 4'b1000, "R3 high pick from pointer");
        step(4'b1010, 4'b1000, "R6 count 3 to 2");
        step(4'b1010, 4'b1000, "R6 count 2 to 1");
        step(4'b1010, 4'b1000, "R6 count 1 to 0");
        step(4'b1010, 4'b0010, "R6 expiry after L+1");
        step(4'b0010, 4'b0010, "R6 alone, frozen");
        step(4'b0010, 4'b0010, "R6 alone, frozen");
        step(4'b0010, 4'b0010, "R6 alone, frozen");
        step(4'b1010, 4'b0010, "R6 contended 3 to 2");
        step(4'b1010, 4'b0010, "R6 contended 2 to 1");
        step(4'b1010, 4'b0010, "R6 contended 1 to 0");
        step(4'b1010, 4'b1000, "R6 hand-over");
        drain();

        // Full register reset
        @(negedge clk);
        rst_n = 1'b0;
        chk_gnt(4'b0000, "R1 reset clears grant");
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, 32'h1,   "R1 group map restored");
        rd(2'd1, 32'h0,   "R1 disable restored");
        rd(2'd2, 32'hFFF, "R1 latency restored");
        rd(2'd3, 32'h0,   "R1 timer restored");
        step(4'b1110, 4'b0010, "R4 restart at lowest");
        step(4'b0100, 4'b0100, "R1 R7 master 2 enabled again");
        drain();

        finish_run();
    end

endmodule